// File: doc/BRIEF.md
# Dual Pause Timer Controller

This block keeps the pause state used by full-duplex flow control in an Ethernet MAC. It owns two down-counters measured in pause quanta (one quantum is 512 bit times, signalled by a tick from the MAC). The local timer holds off ordinary frame transmission after a validated pause request arrives from the link partner. The remote timer estimates how long the partner stays silent after this station has transmitted a pause frame of its own.

Normal frames may leave only when `tx_allow` is high. A software request to send a control frame is tracked on its own path and is never held back by the local pause. A small register-style interface sets the two enable bits and raises the send request. A status bit reports that the transmit engine has started the control frame. Both counters are visible on output ports for reading.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset both counters are zero, `tx_allow` is high, `ctrl_tx_req` and `ctrl_sent` are low, and both enable outputs are high.
- R2: When `rx_pause_vld` is high and the flow enable is set, `local_cnt` takes `rx_pause_time` on the next cycle, even if it was still counting.
- R3: Without a load, each `quanta_tick` lowers a nonzero counter by one on the next cycle, and a counter at zero stays at zero. A load in the same cycle as a tick takes priority.
- R4: A received pause request with time zero clears `local_cnt`, so `tx_allow` is high on the next cycle.
- R5: `tx_allow` is low exactly when the flow enable is set and `local_cnt` is nonzero.
- R6: While the flow enable is clear, `rx_pause_vld` leaves `local_cnt` unchanged. The counter still counts down on ticks.
- R7: When `tx_pause_done` is high and the remote enable is set, `remote_cnt` takes `tx_pause_time` on the next cycle. With the remote enable clear, `tx_pause_done` is ignored. Ticks lower `remote_cnt` as in R3.
- R8: A write with `csr_wr_data[2]` set raises `ctrl_tx_req` on the next cycle. The request stays high whatever the pause state. `ctrl_tx_start` clears it one cycle later. If a new set arrives in the same cycle as the clear, the set wins.
- R9: `ctrl_sent` goes high the cycle after `ctrl_tx_start` arrives while `ctrl_tx_req` is high. It goes low the cycle after `stat_rd`. If both happen in the same cycle, the set wins.
- R10: A write (`csr_wr` high) loads the flow enable from `csr_wr_data[0]` and the remote enable from `csr_wr_data[1]`. Both show on `flow_en_o` and `remote_en_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| rx_pause_vld | input | 1 | Validated pause request received |
| rx_pause_time | input | TIMER_W | Pause time of the received request, in quanta |
| tx_pause_done | input | 1 | Own pause frame transmission finished |
| tx_pause_time | input | TIMER_W | Pause time carried in the transmitted frame |
| csr_wr | input | 1 | Control register write strobe |
| csr_wr_data | input | 3 | bit0 flow enable, bit1 remote enable, bit2 send control frame |
| stat_rd | input | 1 | Status read strobe, clears `ctrl_sent` |
| ctrl_tx_start | input | 1 | Transmit engine has started the control frame |
| tx_allow | output | 1 | Normal frames may be sent |
| ctrl_tx_req | output | 1 | Control frame pending, not gated by pause |
| ctrl_sent | output | 1 | Control frame started since the last status read |
| flow_en_o | output | 1 | Current flow enable |
| remote_en_o | output | 1 | Current remote tracking enable |
| local_cnt | output | TIMER_W | Local pause timer value |
| remote_cnt | output | TIMER_W | Remote pause estimate value |

## Verification
Every registered result (both counters, the request, the status bit and the enables) is due one clock after the input that causes it. `tx_allow` follows those registers within the same cycle. The bench applies inputs on the falling edge. Its reference model steps on the rising edge, using the inputs then present. All outputs are compared at the next falling edge, exactly one register stage after the stimulus, so no check waits on a window or depends on the order of processes at an edge.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   localparam int NUM_TMR    = 2;
   localparam int TMR_LOCAL  = 0;
   localparam int TMR_REMOTE = 1;
   localparam int CSR_W      = 3;

   // write layout: bit2 send, bit1 remote tracking, bit0 flow enable
   typedef struct packed {
      logic send;
      logic remote_en;
      logic flow_en;
   } pfc_csr_t;

endpackage

// File: rtl/pfc_quanta_timer.sv
module pfc_quanta_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] ONE = W'(1);

   logic nonzero;
   assign nonzero = |cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (tick && nonzero) begin
         cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/pfc_csr.sv
module pfc_csr
   import pfc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CSR_W-1:0] wdata,
   output logic             flow_en,
   output logic             remote_en,
   output logic             send_set
);

   pfc_csr_t wr_fields;
   assign wr_fields = pfc_csr_t'(wdata);
   assign send_set  = wr && wr_fields.send;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flow_en   <= 1'b1;
         remote_en <= 1'b1;
      end else if (wr) begin
         flow_en   <= wr_fields.flow_en;
         remote_en <= wr_fields.remote_en;
      end
   end

endmodule

// File: rtl/pfc_ctrl_req.sv
module pfc_ctrl_req (
   input  logic clk,
   input  logic rst_n,
   input  logic send_set,
   input  logic start,
   input  logic stat_rd,
   output logic req,
   output logic sent
);

   logic start_hit;
   assign start_hit = start && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req  <= 1'b0;
         sent <= 1'b0;
      end else begin
         if (send_set)       req <= 1'b1;
         else if (start_hit) req <= 1'b0;

         if (start_hit)      sent <= 1'b1;
         else if (stat_rd)   sent <= 1'b0;
      end
   end

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
   import pfc_pkg::*;
#(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               quanta_tick,
   input  logic               rx_pause_vld,
   input  logic [TIMER_W-1:0] rx_pause_time,
   input  logic               tx_pause_done,
   input  logic [TIMER_W-1:0] tx_pause_time,
   input  logic               csr_wr,
   input  logic [2:0]         csr_wr_data,
   input  logic               stat_rd,
   input  logic               ctrl_tx_start,
   output logic               tx_allow,
   output logic               ctrl_tx_req,
   output logic               ctrl_sent,
   output logic               flow_en_o,
   output logic               remote_en_o,
   output logic [TIMER_W-1:0] local_cnt,
   output logic [TIMER_W-1:0] remote_cnt
);

   generate
      if (TIMER_W < 1 || TIMER_W > 32) begin : g_bad_width
         $error("pause_flow_ctrl: TIMER_W must lie in 1..32");
      end
   endgenerate

   logic flow_en, remote_en, send_set;

   pfc_csr u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (csr_wr),
      .wdata     (csr_wr_data),
      .flow_en   (flow_en),
      .remote_en (remote_en),
      .send_set  (send_set)
   );

   pfc_ctrl_req u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .send_set (send_set),
      .start    (ctrl_tx_start),
      .stat_rd  (stat_rd),
      .req      (ctrl_tx_req),
      .sent     (ctrl_sent)
   );

   logic [NUM_TMR-1:0]              tmr_load;
   logic [NUM_TMR-1:0][TIMER_W-1:0] tmr_val;
   logic [NUM_TMR-1:0][TIMER_W-1:0] tmr_cnt;

   assign tmr_load[TMR_LOCAL]  = rx_pause_vld && flow_en;
   assign tmr_val[TMR_LOCAL]   = rx_pause_time;
   assign tmr_load[TMR_REMOTE] = tx_pause_done && remote_en;
   assign tmr_val[TMR_REMOTE]  = tx_pause_time;

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         pfc_quanta_timer #(.W(TIMER_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tmr_load[i]),
            .load_val (tmr_val[i]),
            .tick     (quanta_tick),
            .cnt      (tmr_cnt[i])
         );
      end
   endgenerate

   assign local_cnt   = tmr_cnt[TMR_LOCAL];
   assign remote_cnt  = tmr_cnt[TMR_REMOTE];
   assign flow_en_o   = flow_en;
   assign remote_en_o = remote_en;
   assign tx_allow    = !(flow_en && (|tmr_cnt[TMR_LOCAL]));

endmodule

// File: rtl/pause_flow_ctrl_chk.sv
module pause_flow_ctrl_chk #(
   parameter int TIMER_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               quanta_tick,
   input logic               rx_pause_vld,
   input logic [TIMER_W-1:0] rx_pause_time,
   input logic               tx_pause_done,
   input logic [TIMER_W-1:0] tx_pause_time,
   input logic               csr_wr,
   input logic [2:0]         csr_wr_data,
   input logic               stat_rd,
   input logic               ctrl_tx_start,
   input logic               tx_allow,
   input logic               ctrl_tx_req,
   input logic               ctrl_sent,
   input logic               flow_en_o,
   input logic               remote_en_o,
   input logic [TIMER_W-1:0] local_cnt,
   input logic [TIMER_W-1:0] remote_cnt
);

   logic send_wr;
   assign send_wr = csr_wr && csr_wr_data[2];

   // R2
   local_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pause_vld && flow_en_o) |=> local_cnt == $past(rx_pause_time));

   // R3
   local_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (quanta_tick && !(rx_pause_vld && flow_en_o) && local_cnt != '0)
      |=> local_cnt == TIMER_W'($past(local_cnt) - 1'b1));

   // R5
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_en_o && local_cnt != '0) |-> !tx_allow);

   // R6
   rx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pause_vld && !flow_en_o && !quanta_tick) |=> $stable(local_cnt));

   // R7
   remote_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pause_done && remote_en_o) |=> remote_cnt == $past(tx_pause_time));

   // R8
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_tx_start && ctrl_tx_req && !send_wr) |=> !ctrl_tx_req);

   // R9
   sent_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_tx_start && ctrl_tx_req) |=> ctrl_sent);

   // R9
   sent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !(ctrl_tx_start && ctrl_tx_req)) |=> !ctrl_sent);

endmodule

bind pause_flow_ctrl pause_flow_ctrl_chk #(.TIMER_W(TIMER_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .quanta_tick   (quanta_tick),
   .rx_pause_vld  (rx_pause_vld),
   .rx_pause_time (rx_pause_time),
   .tx_pause_done (tx_pause_done),
   .tx_pause_time (tx_pause_time),
   .csr_wr        (csr_wr),
   .csr_wr_data   (csr_wr_data),
   .stat_rd       (stat_rd),
   .ctrl_tx_start (ctrl_tx_start),
   .tx_allow      (tx_allow),
   .ctrl_tx_req   (ctrl_tx_req),
   .ctrl_sent     (ctrl_sent),
   .flow_en_o     (flow_en_o),
   .remote_en_o   (remote_en_o),
   .local_cnt     (local_cnt),
   .remote_cnt    (remote_cnt)
);

// File: tb/pause_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pause_flow_ctrl_tb_top;

   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          quanta_tick = 1'b0;
   logic          rx_pause_vld = 1'b0;
   logic [TW-1:0] rx_pause_time = '0;
   logic          tx_pause_done = 1'b0;
   logic [TW-1:0] tx_pause_time = '0;
   logic          csr_wr = 1'b0;
   logic [2:0]    csr_wr_data = '0;
   logic          stat_rd = 1'b0;
   logic          ctrl_tx_start = 1'b0;
   logic          tx_allow, ctrl_tx_req, ctrl_sent, flow_en_o, remote_en_o;
   logic [TW-1:0] local_cnt, remote_cnt;

   always #4 clk = ~clk;

   pause_flow_ctrl #(.TIMER_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .quanta_tick(quanta_tick),
      .rx_pause_vld(rx_pause_vld), .rx_pause_time(rx_pause_time),
      .tx_pause_done(tx_pause_done), .tx_pause_time(tx_pause_time),
      .csr_wr(csr_wr), .csr_wr_data(csr_wr_data), .stat_rd(stat_rd),
      .ctrl_tx_start(ctrl_tx_start), .tx_allow(tx_allow),
      .ctrl_tx_req(ctrl_tx_req), .ctrl_sent(ctrl_sent),
      .flow_en_o(flow_en_o), .remote_en_o(remote_en_o),
      .local_cnt(local_cnt), .remote_cnt(remote_cnt)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_loc, m_rem;
   bit m_flow, m_rem_en, m_req, m_sent;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_loc = 0; m_rem = 0; m_flow = 1; m_rem_en = 1; m_req = 0; m_sent = 0;
      end else begin
         int nl, nr;
         bit nreq, nsent, hit;
         nl = m_loc;
         if (rx_pause_vld && m_flow) nl = int'(rx_pause_time);
         else if (quanta_tick && m_loc > 0) nl = m_loc - 1;
         nr = m_rem;
         if (tx_pause_done && m_rem_en) nr = int'(tx_pause_time);
         else if (quanta_tick && m_rem > 0) nr = m_rem - 1;
         hit   = ctrl_tx_start && m_req;
         nsent = hit ? 1'b1 : (stat_rd ? 1'b0 : m_sent);
         nreq  = (csr_wr && csr_wr_data[2]) ? 1'b1 : (hit ? 1'b0 : m_req);
         if (csr_wr) begin
            m_flow   = csr_wr_data[0];
            m_rem_en = csr_wr_data[1];
         end
         m_loc = nl; m_rem = nr; m_req = nreq; m_sent = nsent;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2/R3/R4/R6 local_cnt", int'(local_cnt), m_loc);
      chk("R7 remote_cnt", int'(remote_cnt), m_rem);
      chk("R5 tx_allow", int'(tx_allow), int'(!(m_flow && m_loc != 0)));
      chk("R8 ctrl_tx_req", int'(ctrl_tx_req), int'(m_req));
      chk("R9 ctrl_sent", int'(ctrl_sent), int'(m_sent));
      chk("R10 flow_en_o", int'(flow_en_o), int'(m_flow));
      chk("R10 remote_en_o", int'(remote_en_o), int'(m_rem_en));
   endtask

   task automatic clear_inputs();
      quanta_tick = 0; rx_pause_vld = 0; tx_pause_done = 0;
      csr_wr = 0; stat_rd = 0; ctrl_tx_start = 0;
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic step();
      @(negedge clk);
      compare_all();
      clear_inputs();
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 local_cnt", int'(local_cnt), 0);
      chk("R1 remote_cnt", int'(remote_cnt), 0);
      chk("R1 tx_allow", int'(tx_allow), 1);
      chk("R1 ctrl_tx_req", int'(ctrl_tx_req), 0);
      chk("R1 ctrl_sent", int'(ctrl_sent), 0);
      chk("R1 enables", int'({flow_en_o, remote_en_o}), 3);
      rst_n = 1;

      // R2 load, then R3 count down with a tick every cycle
      step(); rx_pause_vld = 1; rx_pause_time = 16'd3;
      step(); chk("R2 loaded", int'(local_cnt), 3);
      quanta_tick = 1;
      step(); quanta_tick = 1;
      step(); chk("R3 decremented", int'(local_cnt), 1);
      // R2 reload while nonzero, same cycle as tick
      rx_pause_vld = 1; rx_pause_time = 16'd9; quanta_tick = 1;
      step(); chk("R2 reload wins", int'(local_cnt), 9);
      // R8 control request not blocked by pause
      csr_wr = 1; csr_wr_data = 3'b111;
      step(); chk("R8 req while paused", int'(ctrl_tx_req), 1);
      chk("R5 paused", int'(tx_allow), 0);
      // R4 zero ends pause
      rx_pause_vld = 1; rx_pause_time = 16'd0;
      step(); chk("R4 tx_allow after zero", int'(tx_allow), 1);
      // R8 and R9 start handshake
      ctrl_tx_start = 1;
      step(); chk("R8 cleared", int'(ctrl_tx_req), 0);
      chk("R9 sent set", int'(ctrl_sent), 1);
      stat_rd = 1;
      step(); chk("R9 sent cleared", int'(ctrl_sent), 0);
      // R7 remote load
      tx_pause_done = 1; tx_pause_time = 16'd5;
      step(); chk("R7 remote loaded", int'(remote_cnt), 5);
      // R10 disable both, R6 and R7 ignored
      csr_wr = 1; csr_wr_data = 3'b000;
      step(); chk("R10 disabled", int'({flow_en_o, remote_en_o}), 0);
      rx_pause_vld = 1; rx_pause_time = 16'd7; tx_pause_done = 1; tx_pause_time = 16'd2;
      step(); chk("R6 rx ignored", int'(local_cnt), 0);
      chk("R7 done ignored", int'(remote_cnt), 5);

      // randomised segments with varying densities
      for (int seg = 0; seg < 6; seg++) begin
         for (int c = 0; c < 1500; c++) begin
            step();
            quanta_tick   = ($urandom_range(0, 9) < 2 + seg);
            rx_pause_vld  = ($urandom_range(0, 19) == 0);
            rx_pause_time = TW'($urandom_range(0, (seg < 3) ? 6 : 40));
            tx_pause_done = ($urandom_range(0, 24) == 0);
            tx_pause_time = TW'($urandom_range(0, 12));
            csr_wr        = ($urandom_range(0, 29) == 0);
            csr_wr_data   = {1'($urandom_range(0, 1)),
                             1'($urandom_range(0, 3) != 0),
                             1'($urandom_range(0, 3) != 0)};
            stat_rd       = ($urandom_range(0, 15) == 0);
            ctrl_tx_start = ($urandom_range(0, 5) == 0);
         end
      end
      step();
      summary();
   end

endmodule